// File: doc/BRIEF.md
# Sequenced 32-bit ALU

This block is an arithmetic/logic unit that offers a 32-bit programming model while containing only a 16-bit adder and logic datapath. A caller starts an operation with a one-cycle strobe. The strobe carries an operation code, a size code, a 32-bit source, a 32-bit destination and the current extend flag. The unit returns the 32-bit result and five condition flags, and it marks their arrival with a one-cycle done pulse.

Byte and word operations complete in a single pass. Their result is merged into the untouched upper bits of the destination. A long operation makes two passes through the 16-bit datapath. The low half goes first, and its carry or borrow is held in a register and fed into the high-half pass. The zero indication of the low half is combined with that of the high half.

Top module: `seq_alu32`

## Requirements
- R1: The operation code selects the function: 0 adds (dst + src), 1 subtracts (dst - src), 2 is bitwise AND, 3 is bitwise OR and 4 is bitwise XOR. Add and subtract use no carry-in from the extend flag.
- R2: The size code selects the width: 0 is byte, 1 is word, and 2 (or 3) is long. A long operation returns the full 32-bit result, with the carry or borrow of bit 15 propagated into bit 16.
- R3: A byte operation writes only result bits 7:0. Result bits 31:8 equal the destination input's bits 31:8.
- R4: A word operation writes only result bits 15:0. Result bits 31:16 equal the destination input's bits 31:16.
- R5: The flags port is packed as {X,N,Z,V,C}, with X in bit 4 and C in bit 0. These flags are judged at the operation's size: bit 7, 15 or 31 is the top bit.
  - N is the top bit of the result.
  - C is the carry out of the top bit for add, and the borrow for subtract.
  - V is two's-complement overflow at that size.
  - Z is set when the active part of the result is zero. For a long operation, Z is set only when both 16-bit halves are zero.
- R6: For add and subtract, X equals C. For logic operations, X equals the x_in input and V and C are 0.
- R7: After a start is accepted at a clock edge, done is high in the following cycle for byte and word. For long, done is high in the second cycle after that edge and low in the first. Result and flags change only when done is high, and they hold otherwise.
- R8: A start that arrives during the second pass of a long operation is ignored. It produces no done pulse and no change to result or flags.
- R9: After reset, result and flags are 0 and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation |
| op | input | 3 | Operation code |
| size | input | 2 | Size code |
| src | input | 32 | Source operand |
| dst | input | 32 | Destination operand, supplies the kept upper bits |
| x_in | input | 1 | Current extend flag |
| result | output | 32 | Merged result |
| flags | output | 5 | {X,N,Z,V,C} |
| done | output | 1 | One-cycle completion pulse |

## Verification
The latched carry between the halves is the stored state most likely to go wrong. A stale or dropped carry shows up at the ports as a result off by 65536, together with a wrong C or V, on the done pulse of that same long operation. The vectors therefore include sums and differences that ripple across bit 15.

A wrong low-half zero latch shows up as a wrong Z, at the same point in time. Those cases are covered by operands where only one half is zero.

A busy flag that stays set too long, or clears too early, shows up within one cycle. It appears either as a missing done pulse or as an extra pulse for a start that should have been ignored.

// File: rtl/seq_alu_pkg.sv
package seq_alu_pkg;

    localparam int ALU_WORD_W = 32;
    localparam int ALU_LANE_W = 8;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } alu_size_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

endpackage

// File: rtl/seq_alu_slice.sv
// One pass of the narrow datapath: add/sub/logic over W bits, with the
// carry and overflow of the low lane reported separately for byte sizes.
module seq_alu_slice
    import seq_alu_pkg::*;
#(
    parameter int W      = 16,
    parameter int LANE_W = 8
) (
    input  alu_op_e          op,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic             cin,
    output logic [W-1:0]     res,
    output logic             is_arith,
    output logic             c_lane,
    output logic             v_lane,
    output logic             c_top,
    output logic             v_top
);
    logic [W:0]      full_ext;
    logic [LANE_W:0] lane_ext;
    logic            sgn_top;
    logic            sgn_lane;

    always_comb begin
        full_ext = '0;
        lane_ext = '0;
        case (op)
            OP_ADD: begin
                full_ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
                lane_ext = {1'b0, a[LANE_W-1:0]} + {1'b0, b[LANE_W-1:0]}
                         + {{LANE_W{1'b0}}, cin};
            end
            OP_SUB: begin
                full_ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
                lane_ext = {1'b0, a[LANE_W-1:0]} - {1'b0, b[LANE_W-1:0]}
                         - {{LANE_W{1'b0}}, cin};
            end
            OP_AND:  full_ext = {1'b0, a & b};
            OP_OR:   full_ext = {1'b0, a | b};
            default: full_ext = {1'b0, a ^ b};
        endcase
    end

    assign res      = full_ext[W-1:0];
    assign is_arith = (op == OP_ADD) || (op == OP_SUB);

    // Signed overflow: operands agree (add) or differ (sub) in sign and
    // the result sign departs from the destination sign.
    assign sgn_top  = (op == OP_ADD) ? (a[W-1] == b[W-1]) : (a[W-1] != b[W-1]);
    assign sgn_lane = (op == OP_ADD) ? (a[LANE_W-1] == b[LANE_W-1])
                                     : (a[LANE_W-1] != b[LANE_W-1]);

    assign c_top  = is_arith & full_ext[W];
    assign c_lane = is_arith & lane_ext[LANE_W];
    assign v_top  = is_arith & sgn_top  & (full_ext[W-1] != a[W-1]);
    assign v_lane = is_arith & sgn_lane & (lane_ext[LANE_W-1] != a[LANE_W-1]);

endmodule

// File: rtl/seq_alu_flags.sv
// Builds the condition codes for the pass that completes an operation.
module seq_alu_flags
    import seq_alu_pkg::*;
#(
    parameter int W      = 16,
    parameter int LANE_W = 8
) (
    input  alu_size_e        size_sel,
    input  logic             is_arith,
    input  logic [W-1:0]     res,
    input  logic             c_lane,
    input  logic             v_lane,
    input  logic             c_top,
    input  logic             v_top,
    input  logic             lo_zero,
    input  logic             x_keep,
    output ccr_t             ccr
);
    logic lane_zero;
    logic full_zero;

    assign lane_zero = (res[LANE_W-1:0] == '0);
    assign full_zero = (res == '0);

    always_comb begin
        ccr = '0;
        case (size_sel)
            SZ_BYTE: begin
                ccr.n = res[LANE_W-1];
                ccr.z = lane_zero;
                ccr.v = v_lane;
                ccr.c = c_lane;
            end
            SZ_WORD: begin
                ccr.n = res[W-1];
                ccr.z = full_zero;
                ccr.v = v_top;
                ccr.c = c_top;
            end
            default: begin
                ccr.n = res[W-1];
                ccr.z = full_zero & lo_zero;
                ccr.v = v_top;
                ccr.c = c_top;
            end
        endcase
        ccr.x = is_arith ? ccr.c : x_keep;
    end

endmodule

// File: rtl/seq_alu32.sv
module seq_alu32
    import seq_alu_pkg::*;
#(
    parameter int DATA_W = ALU_WORD_W,
    parameter int BYTE_W = ALU_LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    input  logic              x_in,
    output logic [DATA_W-1:0] result,
    output logic [4:0]        flags,
    output logic              done
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        logic              busy;
        logic              done;
        alu_op_e           op;
        logic              x;
        logic [HALF_W-1:0] src_hi;
        logic [HALF_W-1:0] dst_hi;
        logic [HALF_W-1:0] res_lo;
        logic              carry;
        logic              lo_zero;
        logic [DATA_W-1:0] result;
        ccr_t              ccr;
    } state_t;

    state_t state_d, state_q;

    alu_op_e           sl_op;
    logic [HALF_W-1:0] sl_a, sl_b, sl_res;
    logic              sl_cin, sl_arith;
    logic              sl_c_lane, sl_v_lane, sl_c_top, sl_v_top;
    alu_size_e         eff_size;
    logic              x_keep;
    ccr_t              pass_ccr;
    logic              busy;

    // Second pass (busy) replays the latched high halves with the carry.
    always_comb begin
        if (state_q.busy) begin
            sl_op    = state_q.op;
            sl_a     = state_q.dst_hi;
            sl_b     = state_q.src_hi;
            sl_cin   = state_q.carry;
            eff_size = SZ_LONG;
            x_keep   = state_q.x;
        end else begin
            sl_op    = alu_op_e'(op);
            sl_a     = dst[HALF_W-1:0];
            sl_b     = src[HALF_W-1:0];
            sl_cin   = 1'b0;
            eff_size = size[1] ? SZ_LONG : alu_size_e'(size);
            x_keep   = x_in;
        end
    end

    seq_alu_slice #(.W(HALF_W), .LANE_W(BYTE_W)) u_slice (
        .op       (sl_op),
        .a        (sl_a),
        .b        (sl_b),
        .cin      (sl_cin),
        .res      (sl_res),
        .is_arith (sl_arith),
        .c_lane   (sl_c_lane),
        .v_lane   (sl_v_lane),
        .c_top    (sl_c_top),
        .v_top    (sl_v_top)
    );

    seq_alu_flags #(.W(HALF_W), .LANE_W(BYTE_W)) u_flags (
        .size_sel (eff_size),
        .is_arith (sl_arith),
        .res      (sl_res),
        .c_lane   (sl_c_lane),
        .v_lane   (sl_v_lane),
        .c_top    (sl_c_top),
        .v_top    (sl_v_top),
        .lo_zero  (state_q.lo_zero),
        .x_keep   (x_keep),
        .ccr      (pass_ccr)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (state_q.busy) begin
            state_d.busy   = 1'b0;
            state_d.done   = 1'b1;
            state_d.result = {sl_res, state_q.res_lo};
            state_d.ccr    = pass_ccr;
        end else if (start) begin
            if (size[1]) begin
                state_d.busy    = 1'b1;
                state_d.op      = alu_op_e'(op);
                state_d.x       = x_in;
                state_d.src_hi  = src[DATA_W-1:HALF_W];
                state_d.dst_hi  = dst[DATA_W-1:HALF_W];
                state_d.res_lo  = sl_res;
                state_d.carry   = sl_c_top;
                state_d.lo_zero = (sl_res == '0);
            end else begin
                state_d.done = 1'b1;
                state_d.ccr  = pass_ccr;
                if (size[0]) begin
                    state_d.result = {dst[DATA_W-1:HALF_W], sl_res};
                end else begin
                    state_d.result = {dst[DATA_W-1:BYTE_W], sl_res[BYTE_W-1:0]};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign busy   = state_q.busy;
    assign result = state_q.result;
    assign flags  = state_q.ccr;
    assign done   = state_q.done;

endmodule

// File: rtl/seq_alu32_chk.sv
module seq_alu32_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        op,
    input logic [1:0]        size,
    input logic [DATA_W-1:0] dst,
    input logic              x_in,
    input logic              busy,
    input logic [DATA_W-1:0] result,
    input logic [4:0]        flags,
    input logic              done
);
    AST_SHORT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !size[1] |=> done && !busy);  // R7

    AST_LONG_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && size[1] |=> busy && !done);  // R7

    AST_LONG_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> done && !busy);  // R8

    AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result) && $stable(flags));  // R7

    AST_BYTE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && size == 2'd0 |=> result[DATA_W-1:8] == $past(dst[DATA_W-1:8]));  // R3

    AST_WORD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && size == 2'd1 |=> result[DATA_W-1:16] == $past(dst[DATA_W-1:16]));  // R4

    AST_LOGIC_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !size[1] && op >= 3'd2
        |=> !flags[1] && !flags[0] && flags[4] == $past(x_in));  // R6

    AST_LONG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done && $past(busy) |-> flags[2] == (result == '0));  // R5

endmodule

bind seq_alu32 seq_alu32_chk #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op     (op),
    .size   (size),
    .dst    (dst),
    .x_in   (x_in),
    .busy   (busy),
    .result (result),
    .flags  (flags),
    .done   (done)
);

// File: tb/seq_alu32_bench.sv
`timescale 1ns/1ps
module seq_alu32_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic [31:0] src = '0;
    logic [31:0] dst = '0;
    logic        x_in = 1'b0;
    logic [31:0] result;
    logic [4:0]  flags;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    seq_alu32 u_seq_alu32 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
        .src(src), .dst(dst), .x_in(x_in),
        .result(result), .flags(flags), .done(done)
    );

    // {op[2:0], size[1:0], x, src[31:0], dst[31:0]}
    localparam int NV = 18;
    localparam logic [69:0] VEC [NV] = '{
        {3'd0, 2'd0, 1'b0, 32'h0000_0001, 32'hAABB_CC7F},
        {3'd0, 2'd0, 1'b0, 32'h1234_5601, 32'h0000_00FF},
        {3'd1, 2'd0, 1'b1, 32'h0000_0001, 32'h5555_0000},
        {3'd1, 2'd0, 1'b0, 32'h0000_0001, 32'h0000_0080},
        {3'd0, 2'd1, 1'b0, 32'h0000_0001, 32'h1234_7FFF},
        {3'd1, 2'd1, 1'b0, 32'hFFFF_4321, 32'h9876_4321},
        {3'd0, 2'd1, 1'b0, 32'h0000_0001, 32'h0000_FFFF},
        {3'd0, 2'd2, 1'b0, 32'h0000_0001, 32'h0000_FFFF},
        {3'd0, 2'd2, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF},
        {3'd0, 2'd2, 1'b0, 32'h0000_0001, 32'h7FFF_FFFF},
        {3'd1, 2'd2, 1'b0, 32'h0000_0001, 32'h0001_0000},
        {3'd1, 2'd2, 1'b1, 32'h0000_0001, 32'h0000_0000},
        {3'd0, 2'd2, 1'b0, 32'h0000_0000, 32'h0001_0000},
        {3'd0, 2'd3, 1'b0, 32'h0000_0000, 32'h0000_0001},
        {3'd2, 2'd2, 1'b1, 32'hF0F0_0FF0, 32'hFF00_FF00},
        {3'd3, 2'd1, 1'b0, 32'h0000_8001, 32'hCAFE_0100},
        {3'd4, 2'd0, 1'b1, 32'h0000_00FF, 32'h1111_22FF},
        {3'd2, 2'd2, 1'b0, 32'hFFFF_0000, 32'h0000_FFFF}
    };

    function automatic logic [36:0] ref_model(input logic [2:0] o, input logic [1:0] s,
                                              input logic xi, input logic [31:0] a_src,
                                              input logic [31:0] a_dst);
        int          w;
        logic [32:0] ext;
        logic [31:0] mask, a, b, r;
        logic        cc, vv, nn, zz, xx, arith;
        w     = s[1] ? 32 : (s[0] ? 16 : 8);
        mask  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        a     = a_dst & mask;
        b     = a_src & mask;
        arith = (o == 3'd0) || (o == 3'd1);
        case (o)
            3'd0:    ext = {1'b0, a} + {1'b0, b};
            3'd1:    ext = {1'b0, a} - {1'b0, b};
            3'd2:    ext = {1'b0, a & b};
            3'd3:    ext = {1'b0, a | b};
            default: ext = {1'b0, a ^ b};
        endcase
        r  = ext[31:0] & mask;
        cc = arith ? ((o == 3'd0) ? ext[w] : (a < b)) : 1'b0;
        nn = r[w-1];
        zz = (r == 32'd0);
        vv = 1'b0;
        if (o == 3'd0) vv = (a[w-1] == b[w-1]) && (nn != a[w-1]);
        if (o == 3'd1) vv = (a[w-1] != b[w-1]) && (nn != a[w-1]);
        xx = arith ? cc : xi;
        return {(a_dst & ~mask) | r, xx, nn, zz, vv, cc};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Applies one accepted operation and checks the done timing and outputs.
    task automatic run_op(input logic [69:0] v, input string req);
        logic [36:0] exp;
        exp = ref_model(v[69:67], v[66:65], v[64], v[63:32], v[31:0]);
        @(negedge clk);
        op = v[69:67]; size = v[66:65]; x_in = v[64];
        src = v[63:32]; dst = v[31:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (v[66]) begin
            check("R7", "long done after one cycle", {31'd0, done}, 32'd0);
            @(negedge clk);
        end
        check("R7", "done pulse", {31'd0, done}, 32'd1);
        check(req, "result", result, exp[36:5]);
        check("R5", "flags {X,N,Z,V,C}", {27'd0, flags}, {27'd0, exp[4:0]});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R7 watchdog: actual still running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] held_res;
        logic [4:0]  held_flags;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9", "reset result", result, 32'd0);
        check("R9", "reset flags", {27'd0, flags}, 32'd0);
        check("R9", "reset done", {31'd0, done}, 32'd0);
        rst_n = 1'b1;

        // R1 R2 R3 R4 R5 R6: table walk
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i], VEC[i][66] ? "R2" : (VEC[i][65] ? "R4" : "R3"));
        end

        // R1: subtract direction (dst - src), long
        run_op({3'd1, 2'd2, 1'b0, 32'h0000_0003, 32'h0000_0010}, "R1");

        // R8: start held during the second pass is ignored
        @(negedge clk);
        op = 3'd0; size = 2'd2; x_in = 1'b0; src = 32'h0000_0001; dst = 32'h0000_FFFF;
        start = 1'b1;
        @(negedge clk);
        op = 3'd4; size = 2'd0; src = 32'h0000_00FF; dst = 32'h0000_0000;
        check("R8", "busy pass done", {31'd0, done}, 32'd0);
        @(negedge clk);
        start = 1'b0;
        check("R8", "long done", {31'd0, done}, 32'd1);
        check("R8", "long result", result, 32'h0001_0000);
        @(negedge clk);
        check("R8", "no pulse for ignored start", {31'd0, done}, 32'd0);
        check("R8", "result kept", result, 32'h0001_0000);

        // R7: outputs hold with no start while inputs move
        held_res   = result;
        held_flags = flags;
        op = 3'd1; size = 2'd1; src = 32'hDEAD_BEEF; dst = 32'h0BAD_F00D; x_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R7", "held result", result, held_res);
        check("R7", "held flags", {27'd0, flags}, {27'd0, held_flags});
        check("R7", "no done while idle", {31'd0, done}, 32'd0);

        // R7: back-to-back short operations each pulse done
        @(negedge clk);
        op = 3'd0; size = 2'd0; x_in = 1'b0; src = 32'h0000_0002; dst = 32'h0000_0003;
        start = 1'b1;
        @(negedge clk);
        dst = 32'hFFFF_FF10; src = 32'h0000_0020;
        check("R7", "first of pair done", {31'd0, done}, 32'd1);
        check("R7", "first of pair result", result, 32'h0000_0005);
        @(negedge clk);
        start = 1'b0;
        check("R7", "second of pair done", {31'd0, done}, 32'd1);
        check("R3", "second of pair result", result, 32'hFFFF_FF30);
        @(negedge clk);
        check("R7", "pulse ends", {31'd0, done}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule